// File: doc/BRIEF.md
# Temperature Sensor I2C Target Model

This block is a synthesizable I2C target that stands in for a small digital temperature sensor, so that an I2C master design can be exercised against realistic register traffic. It watches the SCL and SDA lines with a fast system clock, recognises START, repeated START and STOP conditions, and answers only at its fixed 7-bit address. It acknowledges address and data bytes and returns read data by pulling SDA low through an open-drain enable.

A register pointer picks one of a few byte registers. The two temperature bytes come from a parallel input word. A status byte reports that the device is ready. A high-limit byte can be written and read back. The pointer comes out of reset on the temperature high byte, so a read with no pointer write returns the high byte and then the low byte. The pointer advances after every byte that is read or written.

Top module: `tsens_i2c_target`

## Requirements
- R1: The target acknowledges only the address 0x4B (address byte 0x96 for writes, 0x97 for reads). For any other address it leaves SDA released on the ninth pulse and ignores every later byte until the next START, so register contents stay unchanged.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A repeated START in any phase returns the target to address reception.
- R3: After reset the pointer selects register 0x00. A read with no prior pointer write returns temperature bits [15:8] first and then bits [7:0].
- R4: A write transaction is the address with R/W = 0, then one pointer byte, then data bytes. The target pulls SDA low on the ninth pulse of each of these bytes.
- R5: A register read is the address with R/W = 0, then the pointer byte, then a repeated START, then the address with R/W = 1, then the returned data bytes. Bytes are sent most significant bit first.
- R6: During a read, a low SDA from the master on the ninth pulse requests another byte. A high SDA ends the read, and the target then keeps SDA released until the next START or STOP.
- R7: Register 0x02 (status) reads 0x00.
- R8: Register 0x04 (high-limit byte) resets to 0x20 and reads back the last value written to it.
- R9: Register 0x00 returns temperature bits [15:8] and register 0x01 returns bits [7:0]. Both are taken from a single sample of the temperature input, captured when a read address is acknowledged, so a change of the input during a read does not split the word.
- R10: The pointer increments by one after each data byte read or written, and wraps from 0xFF to 0x00.
- R11: Registers other than 0x04 ignore writes. Addresses other than 0x00, 0x01, 0x02 and 0x04 read 0x00.
- R12: The SDA output enable is low after reset and changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must run far faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen at the pin |
| sda_i | input | 1 | I2C data line as seen at the pin |
| sda_oe | output | 1 | High pulls SDA low (open drain); low releases it |
| temp_word | input | 16 | Temperature value; bits [15:3] are two's complement in 1/16 degree steps |

## Verification
Several rules are checked by assertions on every clock. The SDA enable may change only after SCL has been seen low. An idle target never drives the line. Every START re-arms address reception. A foreign address drops the target to idle. The limit byte comes out of reset at its default value. Each pointer step adds exactly one. Writes to any register other than the limit byte leave it unchanged.

Other rules can only be shown by full bus scenarios in the bench: the byte order of reads, the snapshot of the temperature word, repeated-START framing, master NACK handling and read-back of written values. The bench runs directed corner cases, then random temperature words, limit values and start pointers, and compares each result with a register model held in the bench.

// File: rtl/tsens_i2c_pkg.sv
// Shared types for the temperature-sensor I2C target.
// Assumes: register addresses are byte wide; only the listed ones exist.
package tsens_i2c_pkg;

    // Protocol engine phases
    typedef enum logic [2:0] {
        ST_IDLE,     // waiting for START
        ST_ADDR,     // shifting in address byte
        ST_ADDR_ACK, // driving address ACK
        ST_WR_BYTE,  // shifting in pointer or data byte
        ST_WR_ACK,   // driving write ACK
        ST_RD_BYTE,  // shifting out read byte
        ST_RD_ACK    // sampling master ACK/NACK
    } tgt_state_e;

    localparam logic [7:0] REG_TEMP_HI  = 8'h00;
    localparam logic [7:0] REG_TEMP_LO  = 8'h01;
    localparam logic [7:0] REG_STATUS   = 8'h02;
    localparam logic [7:0] REG_LIMIT_HI = 8'h04;

    localparam logic [7:0] STATUS_READY = 8'h00;

endpackage

// File: rtl/tsens_bus_sampler.sv
// Synchronizes SCL and SDA into the system clock domain and derives
// SCL edges plus START and STOP conditions.
// Assumes: clk is much faster than SCL; STAGES >= 2; both lines use the
// same depth so their relative order is kept.
module tsens_bus_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    // Synchronizer chains; lines idle high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    // One-cycle history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/tsens_i2c_engine.sv
// Byte-level I2C target protocol: address match, ACK generation, write
// byte capture and read byte shifting.
// Assumes: inputs come from tsens_bus_sampler; bits are sampled on SCL
// rise and SDA is only changed right after an SCL fall.
module tsens_i2c_engine
    import tsens_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h4B
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_s,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_byte,
    output logic       sda_oe,
    output logic       snap_en,
    output logic       ptr_load,
    output logic       ptr_inc,
    output logic       wr_en,
    output logic [7:0] wr_data
);

    localparam int CNT_W = 4;
    localparam logic [CNT_W-1:0] BITS_PER_BYTE = CNT_W'(8);

    tgt_state_e       state;
    logic [CNT_W-1:0] bitcnt;
    logic [7:0]       shreg;
    logic             rw_q;
    logic             first_q;
    logic             more_q;
    logic             sda_oe_q;

    assign sda_oe  = sda_oe_q;
    assign wr_data = shreg;

    // Protocol sequencer: one transition per bus event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            rw_q     <= 1'b0;
            first_q  <= 1'b0;
            more_q   <= 1'b0;
            sda_oe_q <= 1'b0;
            snap_en  <= 1'b0;
            ptr_load <= 1'b0;
            ptr_inc  <= 1'b0;
            wr_en    <= 1'b0;
        end else begin
            snap_en  <= 1'b0;
            ptr_load <= 1'b0;
            ptr_inc  <= 1'b0;
            wr_en    <= 1'b0;
            if (start_det) begin
                state    <= ST_ADDR;
                bitcnt   <= '0;
                sda_oe_q <= 1'b0;
            end else if (stop_det) begin
                state    <= ST_IDLE;
                sda_oe_q <= 1'b0;
            end else begin
                case (state)
                    ST_IDLE: ;
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + CNT_W'(1);
                        end else if (scl_fall && bitcnt == BITS_PER_BYTE) begin
                            if (shreg[7:1] == DEV_ADDR) begin
                                sda_oe_q <= 1'b1;
                                rw_q     <= shreg[0];
                                snap_en  <= shreg[0];
                                state    <= ST_ADDR_ACK;
                            end else begin
                                sda_oe_q <= 1'b0;
                                state    <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            if (rw_q) begin
                                shreg    <= {rd_byte[6:0], 1'b0};
                                sda_oe_q <= ~rd_byte[7];
                                bitcnt   <= CNT_W'(1);
                                state    <= ST_RD_BYTE;
                            end else begin
                                sda_oe_q <= 1'b0;
                                bitcnt   <= '0;
                                first_q  <= 1'b1;
                                state    <= ST_WR_BYTE;
                            end
                        end
                    end
                    ST_WR_BYTE: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + CNT_W'(1);
                        end else if (scl_fall && bitcnt == BITS_PER_BYTE) begin
                            sda_oe_q <= 1'b1;
                            ptr_load <= first_q;
                            wr_en    <= ~first_q;
                            first_q  <= 1'b0;
                            state    <= ST_WR_ACK;
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            sda_oe_q <= 1'b0;
                            bitcnt   <= '0;
                            state    <= ST_WR_BYTE;
                        end
                    end
                    ST_RD_BYTE: begin
                        if (scl_fall) begin
                            if (bitcnt != BITS_PER_BYTE) begin
                                sda_oe_q <= ~shreg[7];
                                shreg    <= {shreg[6:0], 1'b0};
                                bitcnt   <= bitcnt + CNT_W'(1);
                            end else begin
                                sda_oe_q <= 1'b0;
                                ptr_inc  <= 1'b1;
                                state    <= ST_RD_ACK;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            more_q <= ~sda_s;
                        end else if (scl_fall) begin
                            if (more_q) begin
                                shreg    <= {rd_byte[6:0], 1'b0};
                                sda_oe_q <= ~rd_byte[7];
                                bitcnt   <= CNT_W'(1);
                                state    <= ST_RD_BYTE;
                            end else begin
                                sda_oe_q <= 1'b0;
                                state    <= ST_IDLE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_SDA_CHANGES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_q) |-> !$past(scl_s)); // R12

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe_q); // R6

    AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR && bitcnt == '0)); // R2

    AST_FOREIGN_ADDR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && scl_fall && bitcnt == BITS_PER_BYTE && shreg[7:1] != DEV_ADDR)
        |=> (state == ST_IDLE && !sda_oe_q)); // R1

endmodule

// File: rtl/tsens_regfile.sv
// Register pointer, high-limit register and temperature snapshot, with
// the combinational read multiplexer that feeds the protocol engine.
// Assumes: control inputs are single-cycle pulses from tsens_i2c_engine.
module tsens_regfile
    import tsens_i2c_pkg::*;
#(
    parameter int         TEMP_W      = 16,
    parameter logic [7:0] LIMIT_RESET = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_word,
    input  logic              snap_en,
    input  logic              ptr_load,
    input  logic              ptr_inc,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_byte
);

    localparam int HI_LSB = TEMP_W - 8;

    logic [7:0]        ptr_q;
    logic [7:0]        limit_q;
    logic [TEMP_W-1:0] snap_q;

    // Pointer: loaded by the first write byte, stepped after each data byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= REG_TEMP_HI;
        end else if (ptr_load) begin
            ptr_q <= wr_data;
        end else if (ptr_inc || wr_en) begin
            ptr_q <= ptr_q + 8'd1;
        end
    end

    // High-limit register: the only writable location
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= LIMIT_RESET;
        end else if (wr_en && ptr_q == REG_LIMIT_HI) begin
            limit_q <= wr_data;
        end
    end

    // Temperature snapshot taken when a read address is acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (snap_en) begin
            snap_q <= temp_word;
        end
    end

    // Read multiplexer for the byte under the pointer
    always_comb begin
        case (ptr_q)
            REG_TEMP_HI:  rd_byte = snap_q[TEMP_W-1:HI_LSB];
            REG_TEMP_LO:  rd_byte = snap_q[7:0];
            REG_STATUS:   rd_byte = STATUS_READY;
            REG_LIMIT_HI: rd_byte = limit_q;
            default:      rd_byte = 8'h00;
        endcase
    end

    AST_LIMIT_RESET_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (limit_q == LIMIT_RESET)); // R8

    AST_PTR_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((ptr_inc || wr_en) && !ptr_load) |=> (ptr_q == $past(ptr_q) + 8'd1)); // R10

    AST_OTHER_WRITE_KEEPS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr_q != REG_LIMIT_HI) |=> $stable(limit_q)); // R11

endmodule

// File: rtl/tsens_i2c_target.sv
// Top level of the temperature-sensor I2C target: bus sampler, protocol
// engine and register file.
// Assumes: SCL and SDA are open-drain lines; the caller ANDs sda_oe into
// the bus as an active pull-down.
module tsens_i2c_target #(
    parameter logic [6:0] DEV_ADDR    = 7'h4B,
    parameter int         SYNC_STAGES = 2,
    parameter int         TEMP_W      = 16,
    parameter logic [7:0] LIMIT_RESET = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [TEMP_W-1:0] temp_word
);

    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       snap_en, ptr_load, ptr_inc, wr_en;
    logic [7:0] wr_data, rd_byte;

    tsens_bus_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    tsens_i2c_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_byte   (rd_byte),
        .sda_oe    (sda_oe),
        .snap_en   (snap_en),
        .ptr_load  (ptr_load),
        .ptr_inc   (ptr_inc),
        .wr_en     (wr_en),
        .wr_data   (wr_data)
    );

    tsens_regfile #(.TEMP_W(TEMP_W), .LIMIT_RESET(LIMIT_RESET)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .temp_word (temp_word),
        .snap_en   (snap_en),
        .ptr_load  (ptr_load),
        .ptr_inc   (ptr_inc),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_byte   (rd_byte)
    );

endmodule

// File: tb/tb_tsens_i2c_target.sv
module tb_tsens_i2c_target;

    localparam int Q = 6;            // quarter SCL period in clocks
    localparam int WATCHDOG = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_low = 1'b0;
    logic [15:0] temp_word = 16'h0DC8;
    wire         sda_oe;
    wire         sda_bus = ~(m_low | sda_oe);

    int          checks = 0;
    int          failures = 0;
    int          cyc = 0;
    logic [7:0]  lim_model = 8'h20;
    logic [7:0]  rbuf [0:3];

    always #5 clk = ~clk;

    tsens_i2c_target dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (m_scl),
        .sda_i     (sda_bus),
        .sda_oe    (sda_oe),
        .temp_word (temp_word)
    );

    function automatic logic [7:0] exp_reg(input logic [7:0] p, input logic [15:0] t,
                                           input logic [7:0] lim);
        case (p)
            8'h00:   return t[15:8];
            8'h01:   return t[7:0];
            8'h04:   return lim;
            default: return 8'h00;
        endcase
    endfunction

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WATCHDOG) begin
            failures = failures + 1;
            $display("FAIL watchdog actual=%0d expected<%0d cycles", cyc, WATCHDOG);
            report();
        end
    end

    task automatic wq(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        m_low = ~b; wq(Q);
        m_scl = 1'b1; wq(2 * Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic recv_bit(output logic b);
        m_low = 1'b0; wq(Q);
        m_scl = 1'b1; wq(Q);
        b = sda_bus; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_start();
        m_low = 1'b1; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_rstart();
        m_low = 1'b0; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_low = 1'b1; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_low = 1'b0; wq(2 * Q);
    endtask

    task automatic wbyte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic rbyte(output logic [7:0] d, input logic mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(~mack);
    endtask

    // pointer write followed by n data bytes (R4)
    task automatic wr_regs(input logic [7:0] p, input int n, input logic [7:0] d0,
                           input logic [7:0] d1);
        logic a;
        bus_start();
        wbyte(8'h96, a); chk("R4 address ACK", a, 1'b1);
        wbyte(p, a);     chk("R4 pointer ACK", a, 1'b1);
        if (n > 0) begin wbyte(d0, a); chk("R4 data ACK", a, 1'b1); end
        if (n > 1) begin wbyte(d1, a); chk("R4 data ACK", a, 1'b1); end
        bus_stop();
    endtask

    // pointer write, repeated START, n byte read (R5)
    task automatic rd_regs(input logic [7:0] p, input int n);
        logic a;
        bus_start();
        wbyte(8'h96, a); chk("R5 write address ACK", a, 1'b1);
        wbyte(p, a);     chk("R5 pointer ACK", a, 1'b1);
        bus_rstart();
        wbyte(8'h97, a); chk("R5 read address ACK", a, 1'b1);
        for (int i = 0; i < n; i++) rbyte(rbuf[i], i != n - 1);
        bus_stop();
    endtask

    initial begin
        logic a;
        logic [7:0] d;
        logic [15:0] t;
        logic [7:0] v, p;

        void'($urandom(32'h5EED));
        wq(4);
        rst_n = 1'b1;
        wq(3);
        chk("R12 SDA released after reset", {15'd0, sda_oe}, 16'd0);

        // R3: bare read from the reset pointer
        bus_start();
        wbyte(8'h97, a); chk("R1 own address ACK", a, 1'b1);
        rbyte(rbuf[0], 1'b1);
        rbyte(rbuf[1], 1'b0);
        bus_stop();
        chk("R3 bare read high byte", rbuf[0], 8'h0D);
        chk("R3 bare read low byte", rbuf[1], 8'hC8);

        // R8 reset value, R7 status
        rd_regs(8'h04, 1); chk("R8 limit reset value", rbuf[0], 8'h20);
        rd_regs(8'h02, 1); chk("R7 status reads zero", rbuf[0], 8'h00);

        // R8 write and read back
        wr_regs(8'h04, 1, 8'h0E, 8'h00); lim_model = 8'h0E;
        rd_regs(8'h04, 1); chk("R8 limit read back", rbuf[0], 8'h0E);

        // R10/R11: auto-increment across undefined and limit registers
        wr_regs(8'h03, 2, 8'hAA, 8'h33); lim_model = 8'h33;
        rd_regs(8'h03, 3);
        chk("R11 undefined reads zero", rbuf[0], 8'h00);
        chk("R10 increment onto limit", rbuf[1], 8'h33);
        chk("R10 increment past limit", rbuf[2], 8'h00);

        // R11: writes to temperature and status ignored
        wr_regs(8'h00, 2, 8'h77, 8'h66);
        wr_regs(8'h02, 1, 8'h55, 8'h00);
        rd_regs(8'h00, 3);
        chk("R11 temp high unchanged", rbuf[0], 8'h0D);
        chk("R11 temp low unchanged", rbuf[1], 8'hC8);
        chk("R11 status unchanged", rbuf[2], 8'h00);

        // R10: wrap from 0xFF to 0x00
        rd_regs(8'hFF, 2);
        chk("R10 read at 0xFF", rbuf[0], 8'h00);
        chk("R10 wrap to 0x00", rbuf[1], 8'h0D);

        // R1: foreign address is ignored
        bus_start();
        wbyte(8'h94, a); chk("R1 foreign address NACK", a, 1'b0);
        wbyte(8'h04, a); chk("R1 later byte NACK", a, 1'b0);
        wbyte(8'h99, a); chk("R1 later byte NACK", a, 1'b0);
        bus_stop();
        rd_regs(8'h04, 1); chk("R1 limit untouched", rbuf[0], lim_model);

        // R6: after master NACK the line stays released
        bus_start();
        wbyte(8'h97, a);
        rbyte(d, 1'b0);
        rbyte(d, 1'b0);
        chk("R6 SDA released after NACK", d, 8'hFF);
        bus_stop();

        // R9: snapshot holds the word across a read
        temp_word = 16'h1234;
        bus_start();
        wbyte(8'h96, a);
        wbyte(8'h00, a);
        bus_rstart();
        wbyte(8'h97, a);
        rbyte(rbuf[0], 1'b1);
        temp_word = 16'hABCD;
        rbyte(rbuf[1], 1'b0);
        bus_stop();
        chk("R9 snapshot high", rbuf[0], 8'h12);
        chk("R9 snapshot low", rbuf[1], 8'h34);
        rd_regs(8'h00, 2);
        chk("R9 new sample high", rbuf[0], 8'hAB);
        chk("R9 new sample low", rbuf[1], 8'hCD);

        // R2: repeated START during a write restarts address reception
        bus_start();
        wbyte(8'h96, a);
        wbyte(8'h04, a);
        bus_rstart();
        wbyte(8'h96, a); chk("R2 address after repeated START", a, 1'b1);
        wbyte(8'h04, a);
        wbyte(8'h11, a); chk("R2 data ACK after repeated START", a, 1'b1);
        bus_stop();
        lim_model = 8'h11;
        rd_regs(8'h04, 1); chk("R2 write after repeated START", rbuf[0], 8'h11);

        // Random mix checked against the bench model
        for (int k = 0; k < 20; k++) begin
            t = 16'($urandom);
            v = 8'($urandom);
            p = 8'($urandom % 6);
            temp_word = t;
            wr_regs(8'h04, 1, v, 8'h00);
            lim_model = v;
            rd_regs(p, 2);
            chk("R9 R10 random read first", rbuf[0], exp_reg(p, t, lim_model));
            chk("R9 R10 random read second", rbuf[1], exp_reg(p + 8'd1, t, lim_model));
        end

        report();
    end

endmodule